// File: doc/BRIEF.md
# Pipeline Interlock Stall Generator

This block sits beside the decode stage of a small in-order processor. It watches the instruction now in decode together with a record of the instruction that left decode just before it. It then decides whether the pair forms a read-after-side-effect hazard and, if so, holds decode for one or two extra state times. The block does no decoding of its own. The decoder supplies four "producer" flags and four "reader" flags for the instruction it presents.

The producer flags say that the instruction auto-modifies a general register used as a pointer, writes the special-function-register space, updates the status flags as a side effect, or loads the stack pointer explicitly. The reader flags say that the instruction reads internal RAM through a pointer, reads a special-function register, reads the status word, or bumps the stack pointer implicitly.

When decode retires an instruction, the block stores that instruction's producer flags. It compares them only with the reader flags of the next instruction to retire. A stall is therefore charged only for directly adjacent pairs. The penalty per hazard kind is a parameter. Several hazards at once cost the largest single penalty.

Top module: `interlock_stall`

## Requirements
- R1: An instruction with `ind_ram_rd` set, directly after one that retired with `ptr_mod` set, stalls for PEN_PTR cycles (default 1).
- R2: An instruction with `sfr_rd` set, directly after one that retired with `sfr_wr` set, stalls for PEN_SFR cycles (default 1).
- R3: An instruction with `psw_rd` set, directly after one that retired with `flag_upd` set, stalls for PEN_FLAG cycles (default 2).
- R4: An instruction with `sp_adj` set, directly after one that retired with `sp_wr` set, stalls for PEN_SP cycles (default 2).
- R5: An instruction with no reader flag set, or whose reader flags match no producer flag of its predecessor (a direct operand read), does not stall.
- R6: The hazard applies only to adjacent instructions. When any instruction retires in between, the stall disappears.
- R7: When several hazards are present at once, the stall length is the largest of their penalties, not the sum.
- R8: On the first decode cycle of an instruction, `stall_cnt` shows its full penalty. It then falls by one each cycle. `stall_active` is high exactly while `stall_cnt` is nonzero, and the instruction retires in the first cycle with `stall_cnt` zero.
- R9: Reset clears the stored producer flags, so the first instruction after reset never stalls, and both outputs are zero while no instruction is in decode.
- R10: The stored producer flags change only when an instruction retires, that is, with `dec_valid` high and `stall_active` low. Stall cycles and cycles with `dec_valid` low leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state time per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | An instruction is present in decode |
| ptr_mod | input | 1 | Producer: auto-increments or auto-decrements a general register |
| sfr_wr | input | 1 | Producer: writes the special-function-register space |
| flag_upd | input | 1 | Producer: implicitly updates the status flags |
| sp_wr | input | 1 | Producer: explicitly writes the stack pointer |
| ind_ram_rd | input | 1 | Reader: reads internal RAM through a pointer |
| sfr_rd | input | 1 | Reader: reads a special-function register |
| psw_rd | input | 1 | Reader: reads the status word |
| sp_adj | input | 1 | Reader: implicitly increments or decrements the stack pointer |
| stall_active | output | 1 | Hold decode this cycle |
| stall_cnt | output | CNT_W | Stall cycles remaining, counting the current one |

## Verification
The main sweep pairs every one of the 16 producer-flag sets with every one of the 16 reader-flag sets on back-to-back instructions. This sweep separates the four single-hazard lengths, the zero-stall mismatches and the max-not-sum rule for overlapping hazards. The same 256 pairs are then replayed with a neutral instruction placed between them, which shows that only adjacency counts. Directed sequences follow:
- a stalled instruction that is itself a producer, which shows the stored flags come from the instruction that actually retired;
- idle decode cycles between a producer and its reader;
- a reset between a producer and a full reader.

Every cycle of every stall is sampled, to confirm the countdown.

// File: rtl/interlock_stall.sv
module interlock_stall #(
  parameter int PEN_PTR  = 1,
  parameter int PEN_SFR  = 1,
  parameter int PEN_FLAG = 2,
  parameter int PEN_SP   = 2,
  localparam int MAXP_A  = (PEN_PTR > PEN_SFR) ? PEN_PTR : PEN_SFR,
  localparam int MAXP_B  = (PEN_FLAG > PEN_SP) ? PEN_FLAG : PEN_SP,
  localparam int MAXP    = (MAXP_A > MAXP_B) ? MAXP_A : MAXP_B,
  localparam int CNT_W   = (MAXP < 2) ? 1 : $clog2(MAXP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic             ptr_mod,
  input  logic             sfr_wr,
  input  logic             flag_upd,
  input  logic             sp_wr,
  input  logic             ind_ram_rd,
  input  logic             sfr_rd,
  input  logic             psw_rd,
  input  logic             sp_adj,
  output logic             stall_active,
  output logic [CNT_W-1:0] stall_cnt
);

  logic [3:0]       prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             waited_q;
  logic [CNT_W-1:0] pen;

  wire hz_ptr  = prev_q[0] & ind_ram_rd;
  wire hz_sfr  = prev_q[1] & sfr_rd;
  wire hz_flag = prev_q[2] & psw_rd;
  wire hz_sp   = prev_q[3] & sp_adj;

  always_comb begin
    pen = '0;
    if (hz_ptr  && int'(pen) < PEN_PTR)  pen = CNT_W'(PEN_PTR);
    if (hz_sfr  && int'(pen) < PEN_SFR)  pen = CNT_W'(PEN_SFR);
    if (hz_flag && int'(pen) < PEN_FLAG) pen = CNT_W'(PEN_FLAG);
    if (hz_sp   && int'(pen) < PEN_SP)   pen = CNT_W'(PEN_SP);
  end

  assign stall_cnt    = (cnt_q != '0) ? cnt_q
                      : ((dec_valid && !waited_q) ? pen : '0);
  assign stall_active = (stall_cnt != '0);

  wire retire = dec_valid & ~stall_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      cnt_q    <= '0;
      waited_q <= 1'b0;
    end else begin
      if (stall_active) begin
        cnt_q    <= stall_cnt - 1'b1;
        waited_q <= (stall_cnt == CNT_W'(1));
      end else if (retire) begin
        waited_q <= 1'b0;
        prev_q   <= {sp_wr, flag_upd, sfr_wr, ptr_mod};
      end
    end
  end

endmodule

module interlock_stall_chk #(
  parameter int PEN_PTR  = 1,
  parameter int PEN_SFR  = 1,
  parameter int PEN_FLAG = 2,
  parameter int PEN_SP   = 2,
  parameter int MAXP     = 2,
  parameter int CNT_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic             ptr_mod,
  input logic             sfr_wr,
  input logic             flag_upd,
  input logic             sp_wr,
  input logic             ind_ram_rd,
  input logic             sfr_rd,
  input logic             psw_rd,
  input logic             sp_adj,
  input logic             stall_active,
  input logic [CNT_W-1:0] stall_cnt
);
  wire ret = dec_valid && !stall_active;

  a_r1_ptr_hazard: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && ptr_mod) |=> (!(dec_valid && ind_ram_rd) || int'(stall_cnt) >= PEN_PTR));
  a_r2_sfr_hazard: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && sfr_wr) |=> (!(dec_valid && sfr_rd) || int'(stall_cnt) >= PEN_SFR));
  a_r3_flag_hazard: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && flag_upd) |=> (!(dec_valid && psw_rd) || int'(stall_cnt) >= PEN_FLAG));
  a_r4_sp_hazard: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && sp_wr) |=> (!(dec_valid && sp_adj) || int'(stall_cnt) >= PEN_SP));
  a_r6_clean_pred: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ptr_mod && !sfr_wr && !flag_upd && !sp_wr) |=> (stall_cnt == '0));
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stall_cnt) <= MAXP);
  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt != '0) |=> (stall_cnt == $past(stall_cnt) - 1'b1));
endmodule

bind interlock_stall interlock_stall_chk #(
  .PEN_PTR(PEN_PTR), .PEN_SFR(PEN_SFR), .PEN_FLAG(PEN_FLAG), .PEN_SP(PEN_SP),
  .MAXP(MAXP), .CNT_W(CNT_W)
) chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
  .ptr_mod(ptr_mod), .sfr_wr(sfr_wr), .flag_upd(flag_upd), .sp_wr(sp_wr),
  .ind_ram_rd(ind_ram_rd), .sfr_rd(sfr_rd), .psw_rd(psw_rd), .sp_adj(sp_adj),
  .stall_active(stall_active), .stall_cnt(stall_cnt)
);

// File: tb/interlock_stall_test.sv
`timescale 1ns/1ps
module interlock_stall_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic ptr_mod = 0, sfr_wr = 0, flag_upd = 0, sp_wr = 0;
  logic ind_ram_rd = 0, sfr_rd = 0, psw_rd = 0, sp_adj = 0;
  logic       stall_active;
  logic [1:0] stall_cnt;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  interlock_stall uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
    .ptr_mod(ptr_mod), .sfr_wr(sfr_wr), .flag_upd(flag_upd), .sp_wr(sp_wr),
    .ind_ram_rd(ind_ram_rd), .sfr_rd(sfr_rd), .psw_rd(psw_rd), .sp_adj(sp_adj),
    .stall_active(stall_active), .stall_cnt(stall_cnt)
  );

  // bit order of p and r: 0 pointer/RAM, 1 SFR, 2 flags/status, 3 stack pointer
  function automatic int expect_pen(input logic [3:0] p, input logic [3:0] r);
    int e = 0;
    logic [3:0] h = p & r;
    if (h[0] && e < 1) e = 1;
    if (h[1] && e < 1) e = 1;
    if (h[2] && e < 2) e = 2;
    if (h[3] && e < 2) e = 2;
    return e;
  endfunction

  function automatic string pair_tag(input logic [3:0] p, input logic [3:0] r);
    logic [3:0] h = p & r;
    if ($countones(h) > 1) return "R7";
    if (h[0]) return "R1";
    if (h[1]) return "R2";
    if (h[2]) return "R3";
    if (h[3]) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] p, input logic [3:0] r, input int exp, input string tag);
    @(negedge clk);
    dec_valid = 1'b1;
    {sp_wr, flag_upd, sfr_wr, ptr_mod} = p;
    {sp_adj, psw_rd, sfr_rd, ind_ram_rd} = r;
    for (int k = 0; k <= exp + 2; k++) begin
      #1;
      check((k == 0) ? tag : "R8", int'(stall_cnt), exp - k);
      check("R8", int'(stall_active), (exp - k) != 0 ? 1 : 0);
      if (!stall_active) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n, input string tag);
    @(negedge clk);
    dec_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      #1;
      check(tag, int'(stall_cnt), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9", int'(stall_cnt), 0);
    check("R9", int'(stall_active), 0);
    rst_n = 1'b1;
    issue(4'h0, 4'hF, 0, "R9");

    for (int p = 0; p < 16; p++)
      for (int r = 0; r < 16; r++) begin
        issue(4'(p), 4'h0, 0, "R5");
        issue(4'h0, 4'(r), expect_pen(4'(p), 4'(r)), pair_tag(4'(p), 4'(r)));
      end

    for (int p = 0; p < 16; p++)
      for (int r = 0; r < 16; r++) begin
        issue(4'(p), 4'h0, 0, "R5");
        issue(4'h0, 4'h0, 0, "R6");
        issue(4'h0, 4'(r), 0, "R6");
      end

    // R10: a stalled instruction's own producer flags are stored when it retires
    issue(4'b0100, 4'h0, 0, "R5");
    issue(4'b0010, 4'b0100, 2, "R3");
    issue(4'h0, 4'b0010, 1, "R10");
    issue(4'b1000, 4'b0001, 0, "R5");
    issue(4'b0001, 4'b1000, 2, "R4");
    issue(4'h0, 4'b0001, 1, "R10");

    // R10: idle decode cycles do not replace the stored flags
    issue(4'b0100, 4'h0, 0, "R5");
    idle(3, "R10");
    issue(4'h0, 4'b0100, 2, "R10");

    // R9: reset clears stored flags
    issue(4'hF, 4'h0, 0, "R5");
    @(negedge clk);
    dec_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R9", int'(stall_cnt), 0);
    rst_n = 1'b1;
    issue(4'h0, 4'hF, 0, "R9");

    idle(1, "R9");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule